// File: doc/BRIEF.md
# Linked-List Descriptor Queue Manager

This block keeps a set of hardware queues of descriptor addresses. All the queues share one link memory that holds a next-index entry for every descriptor, so a descriptor can sit in any queue and there is no per-queue FIFO storage. A master pushes a descriptor by issuing a write request to a queue and pops one by issuing a read request to the same queue. Each operation takes a fixed two-cycle slot on a valid/ready request channel. The result comes back as a one-cycle response pulse.

On a push, the address is translated to a descriptor index through a small table of memory regions. Each region is described by a base address, a first link index, a descriptor size and a descriptor count. On a pop, the head index is translated back into an address. Every queue keeps its head and tail index, an entry count and a byte total. A status port, indexed by queue number, exposes those values together with the packet length and descriptor size of the head element. A pending line per queue tells consumers that the queue has work.

Top module: `qm_queue_mgr`

## Requirements
- R1: The status port shows, for the queue selected by `stat_queue`, its head index, tail index, entry count, byte total, the stored packet length of the head element, and the descriptor size in bytes of the head element. The last two read 0 when the queue is empty.
- R2: The index value 0x7FFF (15 bits, all ones) means "no descriptor". After reset, and whenever a queue is empty, both its head and its tail hold 0x7FFF and its count is 0.
- R3: A push request (`req_write`=1) appends the translated index of `req_addr` and stores `req_psize` with it. A pop request (`req_write`=0) returns the head descriptor's address on `rsp_data` and removes that index from the queue.
- R4: Pops always take the head. When `q_lifo[q]`=0, a push goes behind the tail, which gives first-in first-out order. When `q_lifo[q]`=1, a push goes in front of the head, which gives last-in first-out order.
- R5: Region r covers the addresses base..base + count*size - 1. The descriptor size is 16 << size_log bytes and the count is 1 << count_log. A region with count_log below 5 is disabled. The index is start + (addr - base) >> (4 + size_log). When regions overlap, the lowest-numbered region decides. A pop maps the index back to base + ((index - start) << (4 + size_log)).
- R6: A pushed address that lies in no enabled region, is not on a descriptor boundary of its region, or maps to an index at or beyond the link depth is dropped. No queue state changes, and `err_flag` is set. `err_flag` stays set until reset.
- R7: `pend[q]` is 1 exactly while queue q holds at least one descriptor.
- R8: A pop of an empty queue returns 0 on `rsp_data` and changes no queue state and no error state.
- R9: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is then 0 for one cycle. `rsp_valid` is 1 for exactly one cycle, starting at the second edge after acceptance. A push returns 0 on `rsp_data`.
- R10: A queue's entry count and byte total change only on the same edge where its head or tail index changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = push, 0 = pop |
| req_queue | input | 2 | Target queue number |
| req_addr | input | 32 | Descriptor address to push |
| req_psize | input | 16 | Packet length in bytes stored with the pushed descriptor |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Popped address, or 0 |
| q_lifo | input | 4 | Per-queue push end select (1 = front) |
| rg_base | input | 64 | Region base addresses, region r at bits [32r+31:32r] |
| rg_start | input | 30 | First link index of each region, 15 bits per region |
| rg_size_log | input | 6 | Descriptor size code of each region, 3 bits per region |
| rg_count_log | input | 8 | Descriptor count code of each region, 4 bits per region |
| pend | output | 4 | Per-queue non-empty indication |
| err_flag | output | 1 | Sticky bad-push flag |
| stat_queue | input | 2 | Queue shown on the status port |
| stat_head | output | 15 | Head index |
| stat_tail | output | 15 | Tail index |
| stat_count | output | 7 | Entry count |
| stat_bytes | output | 24 | Sum of stored packet lengths |
| stat_head_psize | output | 16 | Packet length of the head element |
| stat_head_dsize | output | 12 | Descriptor size in bytes of the head element |

## Verification
The embedded properties watch invariants that must hold on every cycle. An empty count must pair with null head and tail pointers. A pending line implies a valid head. Count and byte changes must move together with a pointer change. The accept-to-response timing and single-cycle response pulse are checked, and the error flag may never drop once raised. The order in which descriptors come back under each push mode cannot be seen by a per-cycle property, so the directed scenarios check it. The same holds for the exact index and address arithmetic at region edges, the rejection of misaligned or out-of-region addresses, and the inert pop of an empty queue.

// File: rtl/qm_pkg.sv
// Shared definitions for the descriptor queue manager.
// Assumes a fixed 15-bit link index whose all-ones value is the null marker.
package qm_pkg;
    localparam int IDX_W = 15;
    localparam logic [IDX_W-1:0] IDX_NULL = '1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WORK = 1'b1
    } qm_state_e;
endpackage

// File: rtl/qm_xlate.sv
// Address-to-index translation over a table of descriptor regions.
// Assumes region bases are 16-byte aligned and sizes are 16 << size_log.
// The lowest-numbered region that contains the address decides the result.
module qm_xlate
    import qm_pkg::*;
#(
    parameter int NR     = 2,
    parameter int ADDR_W = 32,
    parameter int SZL_W  = 3,
    parameter int CTL_W  = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NR*ADDR_W-1:0] rg_base,
    input  logic [NR*IDX_W-1:0]  rg_start,
    input  logic [NR*SZL_W-1:0]  rg_size_log,
    input  logic [NR*CTL_W-1:0]  rg_count_log,
    output logic                 ok,
    output logic [IDX_W-1:0]     idx
);
    localparam int SH_W = 6;

    logic [NR-1:0]    r_in;
    logic [NR-1:0]    r_al;
    logic [IDX_W-1:0] r_idx [NR];

    for (genvar r = 0; r < NR; r++) begin : g_rg
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] off;
        logic [ADDR_W-1:0] slot;
        logic [SH_W-1:0]   sh;
        logic [CTL_W-1:0]  cl;
        assign base = rg_base[r*ADDR_W +: ADDR_W];
        assign cl   = rg_count_log[r*CTL_W +: CTL_W];
        assign sh   = SH_W'(4) + SH_W'(rg_size_log[r*SZL_W +: SZL_W]);
        assign off  = addr - base;
        assign slot = off >> sh;
        // Region hit test: enabled, above base, inside descriptor count.
        always_comb begin
            r_in[r]  = (cl >= CTL_W'(5)) && (addr >= base)
                       && (slot < (ADDR_W'(1) << cl));
            r_al[r]  = (off & ((ADDR_W'(1) << sh) - ADDR_W'(1))) == '0;
            r_idx[r] = rg_start[r*IDX_W +: IDX_W] + slot[IDX_W-1:0];
        end
    end

    // Priority pick: lowest region index wins.
    always_comb begin
        ok  = 1'b0;
        idx = IDX_NULL;
        for (int r = NR - 1; r >= 0; r--) begin
            if (r_in[r]) begin
                ok  = r_al[r];
                idx = r_idx[r];
            end
        end
    end
endmodule

// File: rtl/qm_rev.sv
// Index-to-address translation over the same region table.
// Also reports the byte size of the descriptor. A null or unmapped index
// gives found = 0 with address and size zero.
module qm_rev
    import qm_pkg::*;
#(
    parameter int NR     = 2,
    parameter int ADDR_W = 32,
    parameter int SZL_W  = 3,
    parameter int CTL_W  = 4,
    parameter int DSZ_W  = 4 + (1 << SZL_W)
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic [NR*ADDR_W-1:0] rg_base,
    input  logic [NR*IDX_W-1:0]  rg_start,
    input  logic [NR*SZL_W-1:0]  rg_size_log,
    input  logic [NR*CTL_W-1:0]  rg_count_log,
    output logic                 found,
    output logic [ADDR_W-1:0]    addr,
    output logic [DSZ_W-1:0]     dsize
);
    localparam int SH_W = 6;

    logic [NR-1:0]     r_in;
    logic [ADDR_W-1:0] r_addr [NR];
    logic [DSZ_W-1:0]  r_dsz  [NR];

    for (genvar r = 0; r < NR; r++) begin : g_rg
        logic [IDX_W-1:0] st;
        logic [IDX_W-1:0] rel;
        logic [CTL_W-1:0] cl;
        logic [SH_W-1:0]  sh;
        assign st  = rg_start[r*IDX_W +: IDX_W];
        assign cl  = rg_count_log[r*CTL_W +: CTL_W];
        assign sh  = SH_W'(4) + SH_W'(rg_size_log[r*SZL_W +: SZL_W]);
        assign rel = idx - st;
        // Membership and address rebuild for this region.
        always_comb begin
            r_in[r]   = (cl >= CTL_W'(5)) && (idx != IDX_NULL) && (idx >= st)
                        && (32'(rel) < (32'd1 << cl));
            r_addr[r] = rg_base[r*ADDR_W +: ADDR_W] + (ADDR_W'(rel) << sh);
            r_dsz[r]  = DSZ_W'(16) << rg_size_log[r*SZL_W +: SZL_W];
        end
    end

    // Priority pick: lowest region index wins.
    always_comb begin
        found = 1'b0;
        addr  = '0;
        dsize = '0;
        for (int r = NR - 1; r >= 0; r--) begin
            if (r_in[r]) begin
                found = 1'b1;
                addr  = r_addr[r];
                dsize = r_dsz[r];
            end
        end
    end
endmodule

// File: rtl/qm_link_ram.sv
// Shared link storage: one next-index entry and one packet length per descriptor.
// Assumes the caller only addresses entries below DEPTH. Every next entry
// resets to null. One write port per field; asynchronous read ports.
module qm_link_ram
    import qm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PSZ_W = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nx_we,
    input  logic [AW-1:0]    nx_waddr,
    input  logic [IDX_W-1:0] nx_wdata,
    input  logic [AW-1:0]    nx_raddr,
    output logic [IDX_W-1:0] nx_rdata,
    input  logic             ps_we,
    input  logic [AW-1:0]    ps_waddr,
    input  logic [PSZ_W-1:0] ps_wdata,
    input  logic [AW-1:0]    ps_raddr0,
    output logic [PSZ_W-1:0] ps_rdata0,
    input  logic [AW-1:0]    ps_raddr1,
    output logic [PSZ_W-1:0] ps_rdata1
);
    logic [IDX_W-1:0] nx_mem [DEPTH];
    logic [PSZ_W-1:0] ps_mem [DEPTH];

    // Next-index storage with null reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) nx_mem[i] <= IDX_NULL;
        end else if (nx_we) begin
            nx_mem[nx_waddr] <= nx_wdata;
        end
    end

    // Packet length storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ps_mem[i] <= '0;
        end else if (ps_we) begin
            ps_mem[ps_waddr] <= ps_wdata;
        end
    end

    assign nx_rdata  = nx_mem[nx_raddr];
    assign ps_rdata0 = ps_mem[ps_raddr0];
    assign ps_rdata1 = ps_mem[ps_raddr1];
endmodule

// File: rtl/qm_queue_mgr.sv
// Descriptor queue manager top. It holds the per-queue head/tail/count/byte
// state and runs push and pop through a two-cycle accept/work sequence.
// Queues are threaded through the shared link storage.
// Assumes the region table and q_lifo are static while requests are in flight.
module qm_queue_mgr
    import qm_pkg::*;
#(
    parameter int NQ         = 4,
    parameter int NR         = 2,
    parameter int ADDR_W     = 32,
    parameter int LINK_DEPTH = 64,
    parameter int PSZ_W      = 16,
    parameter int BYTE_W     = 24,
    parameter int SZL_W      = 3,
    parameter int CTL_W      = 4,
    parameter int QID_W      = $clog2(NQ),
    parameter int CNT_W      = $clog2(LINK_DEPTH + 1),
    parameter int DSZ_W      = 4 + (1 << SZL_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [QID_W-1:0]     req_queue,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [PSZ_W-1:0]     req_psize,
    output logic                 rsp_valid,
    output logic [ADDR_W-1:0]    rsp_data,
    input  logic [NQ-1:0]        q_lifo,
    input  logic [NR*ADDR_W-1:0] rg_base,
    input  logic [NR*IDX_W-1:0]  rg_start,
    input  logic [NR*SZL_W-1:0]  rg_size_log,
    input  logic [NR*CTL_W-1:0]  rg_count_log,
    output logic [NQ-1:0]        pend,
    output logic                 err_flag,
    input  logic [QID_W-1:0]     stat_queue,
    output logic [IDX_W-1:0]     stat_head,
    output logic [IDX_W-1:0]     stat_tail,
    output logic [CNT_W-1:0]     stat_count,
    output logic [BYTE_W-1:0]    stat_bytes,
    output logic [PSZ_W-1:0]     stat_head_psize,
    output logic [DSZ_W-1:0]     stat_head_dsize
);
    localparam int AW = $clog2(LINK_DEPTH);

    qm_state_e         state;
    logic              op_push;
    logic [QID_W-1:0]  op_q;
    logic [ADDR_W-1:0] op_addr;
    logic [PSZ_W-1:0]  op_psize;

    logic [IDX_W-1:0]  q_head  [NQ];
    logic [IDX_W-1:0]  q_tail  [NQ];
    logic [CNT_W-1:0]  q_cnt   [NQ];
    logic [BYTE_W-1:0] q_bytes [NQ];

    logic [IDX_W-1:0]  cur_head, cur_tail;
    logic [CNT_W-1:0]  cur_cnt;
    logic              x_ok, push_ok;
    logic [IDX_W-1:0]  x_idx;

    logic              nx_we, ps_we;
    logic [AW-1:0]     nx_waddr;
    logic [IDX_W-1:0]  nx_wdata, nx_rdata;
    logic [PSZ_W-1:0]  ps_rdata0, ps_rdata1;

    logic              pop_found, st_found;
    logic [ADDR_W-1:0] pop_addr, st_addr;
    logic [DSZ_W-1:0]  pop_dsize, st_dsize;

    assign req_ready = (state == ST_IDLE);
    assign cur_head  = q_head[op_q];
    assign cur_tail  = q_tail[op_q];
    assign cur_cnt   = q_cnt[op_q];
    assign push_ok   = x_ok && (32'(x_idx) < LINK_DEPTH);

    qm_xlate #(.NR(NR), .ADDR_W(ADDR_W), .SZL_W(SZL_W), .CTL_W(CTL_W)) u_xlate (
        .addr(op_addr), .rg_base(rg_base), .rg_start(rg_start),
        .rg_size_log(rg_size_log), .rg_count_log(rg_count_log),
        .ok(x_ok), .idx(x_idx)
    );

    qm_rev #(.NR(NR), .ADDR_W(ADDR_W), .SZL_W(SZL_W), .CTL_W(CTL_W), .DSZ_W(DSZ_W)) u_rev_pop (
        .idx(cur_head), .rg_base(rg_base), .rg_start(rg_start),
        .rg_size_log(rg_size_log), .rg_count_log(rg_count_log),
        .found(pop_found), .addr(pop_addr), .dsize(pop_dsize)
    );

    qm_rev #(.NR(NR), .ADDR_W(ADDR_W), .SZL_W(SZL_W), .CTL_W(CTL_W), .DSZ_W(DSZ_W)) u_rev_stat (
        .idx(stat_head), .rg_base(rg_base), .rg_start(rg_start),
        .rg_size_log(rg_size_log), .rg_count_log(rg_count_log),
        .found(st_found), .addr(st_addr), .dsize(st_dsize)
    );

    qm_link_ram #(.DEPTH(LINK_DEPTH), .PSZ_W(PSZ_W), .AW(AW)) u_link (
        .clk(clk), .rst_n(rst_n),
        .nx_we(nx_we), .nx_waddr(nx_waddr), .nx_wdata(nx_wdata),
        .nx_raddr(cur_head[AW-1:0]), .nx_rdata(nx_rdata),
        .ps_we(ps_we), .ps_waddr(x_idx[AW-1:0]), .ps_wdata(op_psize),
        .ps_raddr0(cur_head[AW-1:0]), .ps_rdata0(ps_rdata0),
        .ps_raddr1(stat_head[AW-1:0]), .ps_rdata1(ps_rdata1)
    );

    // Link write selection: one next-entry write per operation.
    always_comb begin
        nx_we    = 1'b0;
        nx_waddr = cur_head[AW-1:0];
        nx_wdata = IDX_NULL;
        ps_we    = 1'b0;
        if (state == ST_WORK) begin
            if (op_push && push_ok) begin
                ps_we = 1'b1;
                if (q_lifo[op_q]) begin
                    nx_we    = 1'b1;
                    nx_waddr = x_idx[AW-1:0];
                    nx_wdata = cur_head;
                end else if (cur_cnt != '0) begin
                    nx_we    = 1'b1;
                    nx_waddr = cur_tail[AW-1:0];
                    nx_wdata = x_idx;
                end
            end else if (!op_push && cur_cnt != '0) begin
                nx_we = 1'b1;
            end
        end
    end

    // Control sequence and per-queue state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_push   <= 1'b0;
            op_q      <= '0;
            op_addr   <= '0;
            op_psize  <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            err_flag  <= 1'b0;
            for (int i = 0; i < NQ; i++) begin
                q_head[i]  <= IDX_NULL;
                q_tail[i]  <= IDX_NULL;
                q_cnt[i]   <= '0;
                q_bytes[i] <= '0;
            end
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_push  <= req_write;
                        op_q     <= req_queue;
                        op_addr  <= req_addr;
                        op_psize <= req_psize;
                        state    <= ST_WORK;
                    end
                end
                ST_WORK: begin
                    state     <= ST_IDLE;
                    rsp_valid <= 1'b1;
                    rsp_data  <= '0;
                    if (op_push) begin
                        if (push_ok) begin
                            q_cnt[op_q]   <= cur_cnt + CNT_W'(1);
                            q_bytes[op_q] <= q_bytes[op_q] + BYTE_W'(op_psize);
                            if (cur_cnt == '0) begin
                                q_head[op_q] <= x_idx;
                                q_tail[op_q] <= x_idx;
                            end else if (q_lifo[op_q]) begin
                                q_head[op_q] <= x_idx;
                            end else begin
                                q_tail[op_q] <= x_idx;
                            end
                        end else begin
                            err_flag <= 1'b1;
                        end
                    end else if (cur_cnt != '0) begin
                        rsp_data      <= pop_found ? pop_addr : '0;
                        q_cnt[op_q]   <= cur_cnt - CNT_W'(1);
                        q_bytes[op_q] <= q_bytes[op_q] - BYTE_W'(ps_rdata0);
                        if (cur_cnt == CNT_W'(1)) begin
                            q_head[op_q] <= IDX_NULL;
                            q_tail[op_q] <= IDX_NULL;
                        end else begin
                            q_head[op_q] <= nx_rdata;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Status view of the selected queue.
    always_comb begin
        stat_head       = q_head[stat_queue];
        stat_tail       = q_tail[stat_queue];
        stat_count      = q_cnt[stat_queue];
        stat_bytes      = q_bytes[stat_queue];
        stat_head_psize = (stat_head == IDX_NULL) ? '0 : ps_rdata1;
        stat_head_dsize = st_found ? st_dsize : '0;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_q
        assign pend[q] = (q_cnt[q] != '0);

        // R2: an empty count always pairs with null head and tail.
        p_empty_null_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (q_cnt[q] == '0) == ((q_head[q] == IDX_NULL) && (q_tail[q] == IDX_NULL)));

        // R7: a pending queue has a real head.
        p_pend_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
            pend[q] |-> (q_head[q] != IDX_NULL));

        // R10: count and bytes move only together with a pointer.
        p_cnt_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
            ((q_cnt[q] != $past(q_cnt[q])) || (q_bytes[q] != $past(q_bytes[q])))
            |-> ((q_head[q] != $past(q_head[q])) || (q_tail[q] != $past(q_tail[q]))));
    end

    // R9: busy right after acceptance, response two edges later.
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));
    p_rsp_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> ##2 rsp_valid);
    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6: error flag never clears while out of reset.
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

// File: tb/qm_queue_mgr_tb.sv
// Directed bench for the descriptor queue manager.
module qm_queue_mgr_tb;
    localparam logic [14:0] NUL = 15'h7FFF;
    localparam logic [31:0] A0 = 32'h1000_0020; // region 0, index 2
    localparam logic [31:0] A1 = 32'h1000_0050; // region 0, index 5
    localparam logic [31:0] A2 = 32'h2000_0080; // region 1, index 34

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_queue = '0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_psize = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [3:0]  q_lifo = 4'b0010;
    logic [63:0] rg_base = {32'h2000_0000, 32'h1000_0000};
    logic [29:0] rg_start = {15'd32, 15'd0};
    logic [5:0]  rg_size_log = {3'd2, 3'd0};
    logic [7:0]  rg_count_log = {4'd5, 4'd5};
    logic [3:0]  pend;
    logic        err_flag;
    logic [1:0]  stat_queue = '0;
    logic [14:0] stat_head, stat_tail;
    logic [6:0]  stat_count;
    logic [23:0] stat_bytes;
    logic [15:0] stat_head_psize;
    logic [11:0] stat_head_dsize;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    qm_queue_mgr u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_queue(req_queue), .req_addr(req_addr), .req_psize(req_psize),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .q_lifo(q_lifo),
        .rg_base(rg_base), .rg_start(rg_start), .rg_size_log(rg_size_log),
        .rg_count_log(rg_count_log), .pend(pend), .err_flag(err_flag),
        .stat_queue(stat_queue), .stat_head(stat_head), .stat_tail(stat_tail),
        .stat_count(stat_count), .stat_bytes(stat_bytes),
        .stat_head_psize(stat_head_psize), .stat_head_dsize(stat_head_dsize)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One request through the handshake; checks the R9 timing.
    task automatic issue(input logic wr, input logic [1:0] q, input logic [31:0] a,
                         input logic [15:0] ps, output logic [31:0] data);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_queue = q; req_addr = a; req_psize = ps;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy", {63'd0, req_ready}, 64'd0);
        chk("R9 no early rsp", {63'd0, rsp_valid}, 64'd0);
        @(negedge clk);
        chk("R9 rsp", {63'd0, rsp_valid}, 64'd1);
        data = rsp_data;
    endtask

    task automatic push(input logic [1:0] q, input logic [31:0] a, input logic [15:0] ps);
        logic [31:0] d;
        issue(1'b1, q, a, ps, d);
        chk("R9 push data", 64'(d), 64'd0);
    endtask

    task automatic pop_exp(input logic [1:0] q, input logic [31:0] exp, input string req);
        logic [31:0] d;
        issue(1'b0, q, 32'd0, 16'd0, d);
        chk(req, 64'(d), 64'(exp));
    endtask

    task automatic stat(input logic [1:0] q, input logic [14:0] h, input logic [14:0] t,
                        input int cnt, input int bytes, input int hps, input int hds);
        stat_queue = q;
        #1;
        chk("R1 head", 64'(stat_head), 64'(h));
        chk("R1 tail", 64'(stat_tail), 64'(t));
        chk("R1 count", 64'(stat_count), 64'(cnt));
        chk("R1 bytes", 64'(stat_bytes), 64'(bytes));
        chk("R1 head psize", 64'(stat_head_psize), 64'(hps));
        chk("R1 head dsize", 64'(stat_head_dsize), 64'(hds));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 ready after reset", {63'd0, req_ready}, 64'd1);
        chk("R7 pend reset", 64'(pend), 64'd0);
        chk("R6 err reset", {63'd0, err_flag}, 64'd0);
        for (int q = 0; q < 4; q++) stat(2'(q), NUL, NUL, 0, 0, 0, 0); // R2
    endtask

    task automatic t_fifo();
        push(2'd0, A0, 16'd100);
        push(2'd0, A1, 16'd200);
        push(2'd0, A2, 16'd300);
        stat(2'd0, 15'd2, 15'd34, 3, 600, 100, 16); // R5 indices, R3
        chk("R7 pend q0", 64'(pend), 64'd1);
        pop_exp(2'd0, A0, "R4 fifo first");
        stat(2'd0, 15'd5, 15'd34, 2, 500, 200, 16);
        pop_exp(2'd0, A1, "R4 fifo second");
        pop_exp(2'd0, A2, "R5 region1 address back");
        stat(2'd0, NUL, NUL, 0, 0, 0, 0); // R2
        chk("R7 pend cleared", 64'(pend), 64'd0);
    endtask

    task automatic t_lifo();
        push(2'd1, A0, 16'd10);
        push(2'd1, A1, 16'd20);
        push(2'd1, A2, 16'd30);
        stat(2'd1, 15'd34, 15'd2, 3, 60, 30, 64); // R4 front push
        chk("R7 pend q1", 64'(pend), 64'd2);
        pop_exp(2'd1, A2, "R4 lifo first");
        pop_exp(2'd1, A1, "R4 lifo second");
        stat(2'd1, 15'd2, 15'd2, 1, 10, 10, 16);
        pop_exp(2'd1, A0, "R4 lifo third");
        stat(2'd1, NUL, NUL, 0, 0, 0, 0);
    endtask

    task automatic t_empty_pop();
        pop_exp(2'd2, 32'd0, "R8 empty pop data");
        stat(2'd2, NUL, NUL, 0, 0, 0, 0); // R8 unchanged
        chk("R8 no error", {63'd0, err_flag}, 64'd0);
        chk("R8 no pend", 64'(pend), 64'd0);
    endtask

    task automatic t_edges();
        push(2'd2, 32'h1000_01F0, 16'd7);  // last of region 0
        stat(2'd2, 15'd31, 15'd31, 1, 7, 7, 16);
        push(2'd3, 32'h2000_07C0, 16'd9);  // last of region 1
        stat(2'd3, 15'd63, 15'd63, 1, 9, 9, 64);
        pop_exp(2'd2, 32'h1000_01F0, "R5 region0 top");
        pop_exp(2'd3, 32'h2000_07C0, "R5 region1 top");
        chk("R6 clean so far", {63'd0, err_flag}, 64'd0);
    endtask

    task automatic t_mixed();
        push(2'd0, A0, 16'd1);
        push(2'd0, A1, 16'd2);
        pop_exp(2'd0, A0, "R3 mixed first");
        push(2'd0, A2, 16'd4);
        stat(2'd0, 15'd5, 15'd34, 2, 6, 2, 16);
        pop_exp(2'd0, A1, "R3 mixed second");
        pop_exp(2'd0, A2, "R3 mixed third");
        stat(2'd0, NUL, NUL, 0, 0, 0, 0); // R10 totals track pointers
    endtask

    task automatic t_bad();
        push(2'd3, 32'h2000_0010, 16'd5); // misaligned within region 1
        chk("R6 err misaligned", {63'd0, err_flag}, 64'd1);
        stat(2'd3, NUL, NUL, 0, 0, 0, 0);
        push(2'd3, 32'h1000_0200, 16'd5); // one past region 0
        stat(2'd3, NUL, NUL, 0, 0, 0, 0);
        push(2'd3, 32'h3000_0000, 16'd5); // no region
        stat(2'd3, NUL, NUL, 0, 0, 0, 0);
        chk("R6 sticky", {63'd0, err_flag}, 64'd1);
        chk("R6 no pend", 64'(pend), 64'd0);
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fifo();
        t_lifo();
        t_empty_pop();
        t_edges();
        t_mixed();
        t_bad();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule